// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This controller sits next to a requester that performs atomic compare-and-swap operations. The requester reports each finished attempt together with its outcome. After a failed attempt the controller holds the requester back for a backoff interval and then grants the retry. The interval is counted in units. It begins at one unit, doubles with every further failure of the same operation, and stops growing at a fixed ceiling. A successful attempt sets it back to one unit.

Two ways of stalling are offered, and the mode input selects one at the moment a failure is reported. In spin mode the controller counts the whole stall itself: each unit lasts a fixed block of 2^UNIT_SHIFT cycles, which stands for a short group of dummy blocking operations. In pause mode the controller does not loop. It hands the requester one pause request that covers the entire interval, with the unit count scaled up by UNIT_SHIFT bits, and grants the retry on the next cycle. The requester then carries out the pause itself.

With the default parameters the ceiling is 4096 units and one unit is 128 cycles.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset, retry_go_o and pause_vld_o are 0, and the first failure uses an interval of 1 unit.
- R2: In spin mode (pause_mode_i = 0 when the failure is reported), retry_go_o stays 0 for exactly units × 2^UNIT_SHIFT cycles after the edge that samples the failure. It is then 1 for exactly one cycle, and pause_vld_o stays 0 throughout.
- R3: Each accepted failure doubles the unit count that the next failure will use.
- R4: The unit count saturates at 2^CAP_LOG2. A failure at the ceiling keeps it at the ceiling.
- R5: An accepted success (done_i = 1, ok_i = 1) sets the unit count back to 1 and raises neither output.
- R6: In pause mode (pause_mode_i = 1 when the failure is reported), pause_vld_o is 1 for exactly one cycle, directly after the sampling edge. In that cycle pause_len_o = units × 2^UNIT_SHIFT. retry_go_o pulses in the following cycle.
- R7: A report on done_i while a stall is in progress has no effect. This holds for success and failure alike, and for the pause-request cycle too: the stall length and the following unit count are unchanged.
- R8: A failure reported in the cycle where retry_go_o is 1 is accepted. It starts a new stall at the already doubled unit count.
- R9: pause_len_o is 0 in every cycle where pause_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Atomic attempt finished this cycle |
| ok_i | input | 1 | Outcome of the attempt: 1 = success, 0 = failure |
| pause_mode_i | input | 1 | Stall style: 0 = spin, 1 = single pause request |
| retry_go_o | output | 1 | One-cycle grant to retry the atomic operation |
| pause_vld_o | output | 1 | Pause request strobe |
| pause_len_o | output | CAP_LOG2+UNIT_SHIFT+1 | Pause length in cycles, valid with the strobe |

## Verification
A new failure report can land in the same cycle that the retry grant is being given. In that cycle, closing the old stall and starting a new one at the doubled count both happen at once. The bench provokes this by raising done_i with a failure on the very cycle it first sees retry_go_o high, in both modes. It then judges the outcome by measuring the length of the new stall, or the value of the new pause request, against the unit count it models arithmetically. Reports that arrive in the middle of a stall are injected as well, and are judged by the unchanged length of that stall and the doubling seen on the stall after it.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPIN  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_GRANT = 2'd3
    } bo_state_e;

    // Stall style picked when a failure is accepted
    typedef enum logic {
        MODE_SPIN  = 1'b0,
        MODE_PAUSE = 1'b1
    } bo_mode_e;

    // Decoded attempt report
    typedef struct packed {
        logic take_fail;
        logic take_ok;
    } bo_event_t;

    // Next unit count: double, but never beyond the ceiling
    function automatic int unsigned double_capped(input int unsigned u,
                                                  input int unsigned cap);
        return (u >= cap) ? cap : (u << 1);
    endfunction

endpackage

// File: rtl/backoff_interval.sv
module backoff_interval
    import backoff_pkg::*;
#(
    parameter int CAP_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  bo_event_t         ev_i,
    output logic [CAP_LOG2:0] units_o
);
    localparam int UW = CAP_LOG2 + 1;
    localparam logic [UW-1:0] ONE = UW'(1);
    localparam logic [UW-1:0] CAP = ONE << CAP_LOG2;

    logic [UW-1:0] units_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            units_q <= ONE;
        end else if (ev_i.take_ok) begin
            units_q <= ONE;
        end else if (ev_i.take_fail) begin
            units_q <= UW'(double_capped(32'(units_q), 32'(CAP)));
        end
    end

    assign units_o = units_q;

    // R4: count stays a power of two inside the ceiling
    a_r4_within_cap: assert property (@(posedge clk) disable iff (rst)
        (units_q <= CAP) && ($countones(units_q) == 1));

    // R3: a failure below the ceiling doubles the count
    a_r3_doubles: assert property (@(posedge clk) disable iff (rst)
        (ev_i.take_fail && !ev_i.take_ok && units_q < CAP) |=> units_q == ($past(units_q) << 1));

    // R4: a failure at the ceiling holds it
    a_r4_hold_at_cap: assert property (@(posedge clk) disable iff (rst)
        (ev_i.take_fail && !ev_i.take_ok && units_q == CAP) |=> units_q == CAP);

    // R5: success returns to one unit
    a_r5_ok_resets: assert property (@(posedge clk) disable iff (rst)
        ev_i.take_ok |=> units_q == ONE);

endmodule

// File: rtl/backoff_stall_timer.sv
module backoff_stall_timer #(
    parameter int LW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    output logic          expired_o
);
    logic [LW-1:0] remain_q;
    logic          running_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (load_i) begin
            remain_q  <= len_i - LW'(1);
            running_q <= 1'b1;
        end else if (running_q) begin
            if (remain_q == '0) begin
                running_q <= 1'b0;
            end else begin
                remain_q <= remain_q - LW'(1);
            end
        end
    end

    assign expired_o = running_q && (remain_q == '0);

    // R2: each running cycle removes exactly one cycle from the stall
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (running_q && remain_q != '0 && !load_i) |=> running_q && (remain_q == $past(remain_q) - LW'(1)));

    // R7: the sequencer never restarts a stall that is still running
    a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !running_q);

endmodule

// File: rtl/backoff_sequencer.sv
module backoff_sequencer
    import backoff_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done_i,
    input  logic      ok_i,
    input  logic      pause_mode_i,
    input  logic      expired_i,
    output bo_event_t ev_o,
    output logic      load_o,
    output logic      retry_go_o,
    output logic      pause_vld_o
);
    bo_state_e state_q, state_d;
    bo_mode_e  mode;
    logic      accept;

    assign mode   = bo_mode_e'(pause_mode_i);
    assign accept = done_i && (state_q == ST_IDLE || state_q == ST_GRANT);

    always_comb begin
        ev_o.take_ok   = accept && ok_i;
        ev_o.take_fail = accept && !ok_i;
        load_o         = ev_o.take_fail && (mode == MODE_SPIN);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GRANT: begin
                if (ev_o.take_fail) begin
                    state_d = (mode == MODE_PAUSE) ? ST_ISSUE : ST_SPIN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SPIN:  state_d = expired_i ? ST_GRANT : ST_SPIN;
            ST_ISSUE: state_d = ST_GRANT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign retry_go_o  = (state_q == ST_GRANT);
    assign pause_vld_o = (state_q == ST_ISSUE);

    // R2: the grant is a single-cycle pulse
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        retry_go_o |=> !retry_go_o);

    // R6: a pause request is followed at once by the grant
    a_r6_issue_then_grant: assert property (@(posedge clk) disable iff (rst)
        pause_vld_o |=> retry_go_o && !pause_vld_o);

    // R7: an unfinished spin stays a spin whatever arrives on done_i
    a_r7_spin_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPIN && !expired_i) |=> state_q == ST_SPIN);

    // R2: spinning never raises the pause strobe or the grant
    a_r2_spin_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPIN) |-> !retry_go_o && !pause_vld_o);

endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl
    import backoff_pkg::*;
#(
    parameter int CAP_LOG2   = 12,
    parameter int UNIT_SHIFT = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         done_i,
    input  logic                         ok_i,
    input  logic                         pause_mode_i,
    output logic                         retry_go_o,
    output logic                         pause_vld_o,
    output logic [CAP_LOG2+UNIT_SHIFT:0] pause_len_o
);
    localparam int LW = CAP_LOG2 + UNIT_SHIFT + 1;

    bo_event_t         ev;
    logic [CAP_LOG2:0] units;
    logic [LW-1:0]     stall_len;
    logic [LW-1:0]     len_q;
    logic              load;
    logic              expired;

    assign stall_len = LW'(units) << UNIT_SHIFT;

    backoff_interval #(.CAP_LOG2(CAP_LOG2)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .units_o (units)
    );

    backoff_stall_timer #(.LW(LW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .len_i     (stall_len),
        .expired_o (expired)
    );

    backoff_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .done_i       (done_i),
        .ok_i         (ok_i),
        .pause_mode_i (pause_mode_i),
        .expired_i    (expired),
        .ev_o         (ev),
        .load_o       (load),
        .retry_go_o   (retry_go_o),
        .pause_vld_o  (pause_vld_o)
    );

    // Whole stall captured once for the single pause request
    always_ff @(posedge clk) begin
        if (rst)               len_q <= '0;
        else if (ev.take_fail) len_q <= stall_len;
    end

    assign pause_len_o = pause_vld_o ? len_q : '0;

    // R9: no length shows without the strobe
    a_r9_len_quiet: assert property (@(posedge clk) disable iff (rst)
        !pause_vld_o |-> pause_len_o == '0);

    // R6: a pause request is one power-of-two block
    a_r6_len_power: assert property (@(posedge clk) disable iff (rst)
        pause_vld_o |-> $countones(pause_len_o) == 1);

    // R1: nothing is signalled in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !retry_go_o && !pause_vld_o);

    generate
        if (UNIT_SHIFT > 0) begin : g_align
            // R6: request is whole units, never a fraction
            a_r6_len_aligned: assert property (@(posedge clk) disable iff (rst)
                pause_vld_o |-> pause_len_o[UNIT_SHIFT-1:0] == '0);
        end
    endgenerate

endmodule

// File: tb/backoff_retry_ctrl_test.sv
module backoff_retry_ctrl_test;
    localparam int CAP_LOG2   = 4;
    localparam int UNIT_SHIFT = 2;
    localparam int CAP        = 1 << CAP_LOG2;
    localparam int UNIT_CYC   = 1 << UNIT_SHIFT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_i = 1'b0;
    logic ok_i = 1'b0;
    logic pause_mode_i = 1'b0;
    logic retry_go_o, pause_vld_o;
    logic [CAP_LOG2+UNIT_SHIFT:0] pause_len_o;

    int checks = 0;
    int errors = 0;
    int exp_u  = 1;
    bit finished = 0;

    backoff_retry_ctrl #(.CAP_LOG2(CAP_LOG2), .UNIT_SHIFT(UNIT_SHIFT)) uut (
        .clk(clk), .rst(rst), .done_i(done_i), .ok_i(ok_i),
        .pause_mode_i(pause_mode_i), .retry_go_o(retry_go_o),
        .pause_vld_o(pause_vld_o), .pause_len_o(pause_len_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inj: 0 none, 1 reports during the spin, 2 success held over the pause cycle
    task automatic fail_run(input bit mode, input bit now, input int inj, input string tag);
        int n = 0;
        int vc = 0;
        int lenv = 0;
        int zbad = 0;
        int unit = exp_u;
        if (!now) @(negedge clk);
        done_i = 1'b1; ok_i = 1'b0; pause_mode_i = mode;
        forever begin
            @(negedge clk);
            done_i = 1'b0;
            if (inj == 2 && n == 0) begin done_i = 1'b1; ok_i = 1'b1; end
            if (inj == 1 && n == 1) begin done_i = 1'b1; ok_i = 1'b1; end
            if (inj == 1 && n == 2) begin done_i = 1'b1; ok_i = 1'b0; end
            if (pause_vld_o) begin
                vc++;
                lenv = int'(pause_len_o);
            end else if (pause_len_o != '0) begin
                zbad++;
            end
            if (retry_go_o) break;
            n++;
            if (n > 50000) break;
        end
        ok_i = 1'b0;
        if (mode) begin
            chk({tag, " R6 stall cycles"}, n, 1);
            chk({tag, " R6 pause strobes"}, vc, 1);
            chk({tag, " R6 pause length"}, lenv, unit * UNIT_CYC);
        end else begin
            chk({tag, " R2 stall cycles"}, n, unit * UNIT_CYC);
            chk({tag, " R2 no pause strobe"}, vc, 0);
        end
        chk({tag, " R9 idle length zero"}, zbad, 0);
        exp_u = (unit >= CAP) ? CAP : unit * 2;
    endtask

    task automatic succeed(input string tag);
        @(negedge clk);
        done_i = 1'b1; ok_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0; ok_i = 1'b0;
        chk({tag, " R5 no grant on success"}, int'(retry_go_o), 0);
        chk({tag, " R5 no pause on success"}, int'(pause_vld_o), 0);
        exp_u = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset grant", int'(retry_go_o), 0);
        chk("R1 reset pause strobe", int'(pause_vld_o), 0);
        chk("R9 reset length", int'(pause_len_o), 0);

        // R1 R2 R3 R4: spin sweep through and beyond the ceiling
        for (int k = 0; k < CAP_LOG2 + 3; k++) fail_run(1'b0, 1'b0, 0, "spin sweep");

        // R5 then R6 R3 R4: pause sweep
        succeed("after spin sweep");
        for (int k = 0; k < CAP_LOG2 + 3; k++) fail_run(1'b1, 1'b0, 0, "pause sweep");

        // alternating modes share one interval
        succeed("after pause sweep");
        for (int k = 0; k < 6; k++) fail_run(k[0], 1'b0, 0, "mixed");

        // R7: reports during a spin and during the pause cycle are ignored
        succeed("before R7");
        fail_run(1'b0, 1'b0, 0, "R7 prime");
        fail_run(1'b0, 1'b0, 1, "R7 spin inject");
        fail_run(1'b0, 1'b0, 0, "R7 after spin inject");
        fail_run(1'b1, 1'b0, 2, "R7 pause inject");
        fail_run(1'b1, 1'b0, 0, "R7 after pause inject");

        // R8: failure reported on the grant cycle
        succeed("before R8");
        fail_run(1'b0, 1'b0, 0, "R8 lead");
        fail_run(1'b0, 1'b1, 0, "R8 spin on grant");
        fail_run(1'b1, 1'b1, 0, "R8 pause on grant");
        fail_run(1'b0, 1'b1, 0, "R8 spin after pause grant");
        for (int k = 0; k < CAP_LOG2; k++) fail_run(k[0], 1'b1, 0, "R8 back to back");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule